// File: doc/BRIEF.md
# Register-File Indirect Address Unit

This block sits between an instruction decoder and the data RAM of a small 8-bit core. It turns the 7-bit file-address field of the current instruction into the 9-bit address the RAM sees. One address is special: file address 00h has no storage behind it. Any access to 00h is taken through the 8-bit pointer register that this block holds. A second file address, 04h, is that pointer register itself. It is read and written here and never in the RAM.

When the pointer in turn selects location 00h, the access goes nowhere. A read returns zero through the read-data override, and a write is dropped. The bank-extension bit that could widen the pointer to nine bits is accepted at the port but has no effect in this variant. The pointer has no reset value, so software must load it before it is used. A pointer write is seen by indirect accesses from the next cycle (the next instruction) onward.

Top module: `indirect_addr_unit`

## Requirements
- R1: When `dir_addr` is not 00h, `ram_addr` equals {`bank_sel`, `dir_addr`}, with `bank_sel` in bits 8:7 and `dir_addr` in bits 6:0.
- R2: When `dir_addr` is 00h, `ram_addr` equals {0, pointer}: bits 7:0 hold the pointer and bit 8 is 0 whatever `irp` is.
- R3: A read (`rd_en`=1) with `dir_addr`=00h while pointer bits 6:0 are 00h raises `rd_ovr_valid` and drives `rd_ovr_data` to 00h in the same cycle.
- R4: A write (`wr_en`=1) with `dir_addr`=00h while pointer bits 6:0 are 00h holds `ram_we` at 0 and leaves the pointer unchanged.
- R5: An access whose resolved address has bits 6:0 other than 00h (indirect) and other than 04h raises `ram_we` in the same cycle for a write, and leaves `rd_ovr_valid` at 0 for a read.
- R6: An access whose resolved address has bits 6:0 equal to 04h (direct, or indirect through the pointer) targets the pointer. A read raises `rd_ovr_valid` with the pointer value, and a write holds `ram_we` at 0 and loads `wr_data` into the pointer at the clock edge.
- R7: A pointer write changes `ram_addr` for indirect accesses from the next cycle onward. In the cycle of the write, the old pointer value is still used.
- R8: While `rst_n` is low, `ram_we` is 0 and pointer writes are ignored. The pointer keeps its value across reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset; blocks writes while low |
| dir_addr | input | 7 | File-address field of the instruction |
| bank_sel | input | 2 | Bank bits for direct accesses |
| irp | input | 1 | Pointer bank-extension bit (ignored in this variant) |
| rd_en | input | 1 | Register-file read strobe |
| wr_en | input | 1 | Register-file write strobe |
| wr_data | input | 8 | Write data (used here for pointer loads) |
| ram_addr | output | 9 | Effective RAM address |
| ram_we | output | 1 | RAM write enable |
| rd_ovr_valid | output | 1 | Replace RAM read data with `rd_ovr_data` |
| rd_ovr_data | output | 8 | Override read data (00h or pointer value) |

## Verification
The bench targets the pointer value with bits 6:0 at zero. A design that decodes the whole 8-bit pointer instead of bits 6:0 would write RAM or return RAM data when bit 7 is set. Indirect loops of the pointer onto itself (pointer = 04h) are driven. A design that treats such an access as ordinary RAM would raise `ram_we` and lose the load. Random `irp` values expose any leak into bit 8. A cycle-exact write-then-use sequence catches a pointer that is bypassed combinationally or loaded a cycle late. A write attempted inside a reset pulse catches a pointer that is cleared by reset or loaded during it.

// File: rtl/iru_pkg.sv
package iru_pkg;
  typedef enum logic [1:0] {
    TGT_RAM  = 2'd0,
    TGT_PTR  = 2'd1,
    TGT_NULL = 2'd2
  } tgt_e;
endpackage

// File: rtl/iru_addr_gen.sv
module iru_addr_gen import iru_pkg::*; #(
  parameter int DIR_W    = 7,
  parameter int DATA_W   = 8,
  parameter int BANK_W   = 2,
  parameter bit IRP_EN   = 1'b0,
  parameter int VOID_LOC = 0,
  parameter int PTR_LOC  = 4
) (
  input  logic [DIR_W-1:0]  dir_addr,
  input  logic [BANK_W-1:0] bank_sel,
  input  logic              irp,
  input  logic [DATA_W-1:0] ptr,
  output logic [DATA_W:0]   eff_addr,
  output logic              via_ptr,
  output tgt_e              tgt
);
  localparam int EFF_W = DATA_W + 1;

  function automatic logic [EFF_W-1:0] direct_ea(input logic [BANK_W-1:0] b,
                                                 input logic [DIR_W-1:0] d);
    logic [EFF_W-1:0] r;
    r = '0;
    r[DIR_W-1:0] = d;
    r[EFF_W-1 -: BANK_W] = b;
    return r;
  endfunction

  function automatic logic [EFF_W-1:0] pointer_ea(input logic x,
                                                  input logic [DATA_W-1:0] p);
    return {x & IRP_EN, p};
  endfunction

  assign via_ptr  = (dir_addr == DIR_W'(VOID_LOC));
  assign eff_addr = via_ptr ? pointer_ea(irp, ptr) : direct_ea(bank_sel, dir_addr);

  always_comb begin
    if (via_ptr && ptr[DIR_W-1:0] == DIR_W'(VOID_LOC))
      tgt = TGT_NULL;
    else if (eff_addr[DIR_W-1:0] == DIR_W'(PTR_LOC))
      tgt = TGT_PTR;
    else
      tgt = TGT_RAM;
  end
endmodule

// File: rtl/iru_access_ctl.sv
module iru_access_ctl import iru_pkg::*; #(
  parameter int DATA_W = 8
) (
  input  logic              rst_n,
  input  logic              rd_en,
  input  logic              wr_en,
  input  tgt_e              tgt,
  input  logic [DATA_W-1:0] ptr,
  output logic              ram_we,
  output logic              ptr_we,
  output logic              ovr_valid,
  output logic [DATA_W-1:0] ovr_data
);
  logic wr_live;
  assign wr_live   = wr_en & rst_n;
  assign ram_we    = wr_live & (tgt == TGT_RAM);
  assign ptr_we    = wr_live & (tgt == TGT_PTR);
  assign ovr_valid = rd_en & (tgt != TGT_RAM);
  assign ovr_data  = (tgt == TGT_PTR) ? ptr : '0;
endmodule

// File: rtl/iru_ptr_reg.sv
module iru_ptr_reg #(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              load,
  input  logic [DATA_W-1:0] din,
  output logic [DATA_W-1:0] q
);
  always_ff @(posedge clk) begin
    if (load) q <= din;
  end
endmodule

// File: rtl/indirect_addr_unit.sv
module indirect_addr_unit import iru_pkg::*; #(
  parameter int DIR_W    = 7,
  parameter int DATA_W   = 8,
  parameter int BANK_W   = 2,
  parameter bit IRP_EN   = 1'b0,
  parameter int VOID_LOC = 0,
  parameter int PTR_LOC  = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [DIR_W-1:0]  dir_addr,
  input  logic [BANK_W-1:0] bank_sel,
  input  logic              irp,
  input  logic              rd_en,
  input  logic              wr_en,
  input  logic [DATA_W-1:0] wr_data,
  output logic [DATA_W:0]   ram_addr,
  output logic              ram_we,
  output logic              rd_ovr_valid,
  output logic [DATA_W-1:0] rd_ovr_data
);
  logic [DATA_W-1:0] fsr_q;
  logic              ptr_we;
  logic              via_ptr;
  tgt_e              tgt;

  iru_addr_gen #(
    .DIR_W(DIR_W), .DATA_W(DATA_W), .BANK_W(BANK_W),
    .IRP_EN(IRP_EN), .VOID_LOC(VOID_LOC), .PTR_LOC(PTR_LOC)
  ) u_agen (
    .dir_addr(dir_addr), .bank_sel(bank_sel), .irp(irp), .ptr(fsr_q),
    .eff_addr(ram_addr), .via_ptr(via_ptr), .tgt(tgt)
  );

  iru_access_ctl #(.DATA_W(DATA_W)) u_ctl (
    .rst_n(rst_n), .rd_en(rd_en), .wr_en(wr_en), .tgt(tgt), .ptr(fsr_q),
    .ram_we(ram_we), .ptr_we(ptr_we),
    .ovr_valid(rd_ovr_valid), .ovr_data(rd_ovr_data)
  );

  iru_ptr_reg #(.DATA_W(DATA_W)) u_ptr (
    .clk(clk), .load(ptr_we), .din(wr_data), .q(fsr_q)
  );
endmodule

// File: rtl/iru_checker.sv
module iru_checker #(
  parameter int DIR_W    = 7,
  parameter int DATA_W   = 8,
  parameter int BANK_W   = 2,
  parameter bit IRP_EN   = 1'b0,
  parameter int VOID_LOC = 0,
  parameter int PTR_LOC  = 4
) (
  input logic              clk,
  input logic              rst_n,
  input logic [DIR_W-1:0]  dir_addr,
  input logic [BANK_W-1:0] bank_sel,
  input logic              rd_en,
  input logic              wr_en,
  input logic [DATA_W-1:0] wr_data,
  input logic [DATA_W:0]   ram_addr,
  input logic              ram_we,
  input logic              rd_ovr_valid,
  input logic [DATA_W-1:0] rd_ovr_data,
  input logic [DATA_W-1:0] fsr_q
);
  logic ind_hit, void_hit, ptr_hit;
  assign ind_hit  = (dir_addr == DIR_W'(VOID_LOC));
  assign void_hit = ind_hit && (fsr_q[DIR_W-1:0] == DIR_W'(VOID_LOC));
  assign ptr_hit  = !void_hit && (ram_addr[DIR_W-1:0] == DIR_W'(PTR_LOC));

  a_r1_direct_addr: assert property (@(posedge clk) disable iff (!rst_n)
    !ind_hit |-> (ram_addr[DIR_W-1:0] == dir_addr && ram_addr[DATA_W -: BANK_W] == bank_sel));

  a_r2_ptr_addr: assert property (@(posedge clk) disable iff (!rst_n)
    ind_hit |-> (ram_addr[DATA_W-1:0] == fsr_q && (IRP_EN || !ram_addr[DATA_W])));

  a_r3_void_reads_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && void_hit) |-> (rd_ovr_valid && rd_ovr_data == '0));

  a_r4_void_no_we: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && void_hit) |-> !ram_we);

  a_r4_void_keeps_ptr: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && void_hit) |=> (fsr_q == $past(fsr_q)));

  a_r6_ptr_load: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && ptr_hit) |=> (fsr_q == $past(wr_data)));

  a_r6_ptr_no_we: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && ptr_hit) |-> !ram_we);

  a_r8_reset_no_we: assert property (@(posedge clk)
    !rst_n |-> !ram_we);
endmodule

bind indirect_addr_unit iru_checker #(
  .DIR_W(DIR_W), .DATA_W(DATA_W), .BANK_W(BANK_W),
  .IRP_EN(IRP_EN), .VOID_LOC(VOID_LOC), .PTR_LOC(PTR_LOC)
) u_chk (
  .clk(clk), .rst_n(rst_n), .dir_addr(dir_addr), .bank_sel(bank_sel),
  .rd_en(rd_en), .wr_en(wr_en), .wr_data(wr_data), .ram_addr(ram_addr),
  .ram_we(ram_we), .rd_ovr_valid(rd_ovr_valid), .rd_ovr_data(rd_ovr_data),
  .fsr_q(fsr_q)
);

// File: tb/indirect_addr_unit_tb.sv
module indirect_addr_unit_tb;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [6:0] dir_addr = '0;
  logic [1:0] bank_sel = '0;
  logic       irp = 1'b0;
  logic       rd_en = 1'b0, wr_en = 1'b0;
  logic [7:0] wr_data = '0;
  logic [8:0] ram_addr;
  logic       ram_we, rd_ovr_valid;
  logic [7:0] rd_ovr_data;

  int total = 0, bad = 0;
  logic [7:0] ptr_m = '0;

  always #4 clk = ~clk;

  indirect_addr_unit u_dut (
    .clk(clk), .rst_n(rst_n), .dir_addr(dir_addr), .bank_sel(bank_sel), .irp(irp),
    .rd_en(rd_en), .wr_en(wr_en), .wr_data(wr_data), .ram_addr(ram_addr),
    .ram_we(ram_we), .rd_ovr_valid(rd_ovr_valid), .rd_ovr_data(rd_ovr_data)
  );

  function automatic logic [8:0] m_addr(input logic [6:0] d, input logic [1:0] b,
                                        input logic [7:0] p);
    if (d == 7'h00) return {1'b0, p};
    return {b, d};
  endfunction

  // 0 = RAM, 1 = pointer register, 2 = void
  function automatic int m_kind(input logic [6:0] d, input logic [1:0] b,
                                input logic [7:0] p);
    logic [8:0] a;
    a = m_addr(d, b, p);
    if (d == 7'h00 && p[6:0] == 7'h00) return 2;
    if (a[6:0] == 7'h04) return 1;
    return 0;
  endfunction

  task automatic check(input string req, input string what,
                       input logic [15:0] act, input logic [15:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  task automatic step(input logic [6:0] d, input logic [1:0] b, input logic x,
                      input logic rd, input logic wr, input logic [7:0] wd);
    int k;
    @(negedge clk);
    dir_addr = d; bank_sel = b; irp = x; rd_en = rd; wr_en = wr; wr_data = wd;
    #2;
    k = m_kind(d, b, ptr_m);
    check(d == 7'h00 ? "R2" : "R1", "ram_addr", 16'(ram_addr), 16'(m_addr(d, b, ptr_m)));
    if (!rst_n)
      check("R8", "ram_we", 16'(ram_we), 16'h0);
    else
      check(k == 2 ? "R4" : (k == 1 ? "R6" : "R5"), "ram_we",
            16'(ram_we), 16'(wr && k == 0));
    check(k == 2 ? "R3" : (k == 1 ? "R6" : "R5"), "ovr_valid",
          16'(rd_ovr_valid), 16'(rd && k != 0));
    if (rd && k != 0)
      check(k == 2 ? "R3" : "R6", "ovr_data", 16'(rd_ovr_data),
            16'(k == 1 ? ptr_m : 8'h00));
    @(posedge clk);
    if (wr && rst_n && k == 1) ptr_m = wd;
  endtask

  initial begin
    #(8 * 200000);
    bad++; total++;
    $display("FAIL watchdog expired");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    int seed;
    seed = int'($urandom(32'h5EED_0042));
    // reset state, R8
    #2;
    check("R8", "ram_we in reset", 16'(ram_we), 16'h0);
    check("R8", "ovr_valid in reset", 16'(rd_ovr_valid), 16'h0);
    @(negedge clk); rst_n = 1'b1;
    // load pointer directly (R6) and read it back
    step(7'h04, 2'd1, 1'b0, 1'b0, 1'b1, 8'h33);
    step(7'h04, 2'd2, 1'b0, 1'b1, 1'b0, 8'h00);
    // R7: same-cycle old value, next-cycle new value
    step(7'h04, 2'd0, 1'b0, 1'b0, 1'b1, 8'h04);
    @(negedge clk);
    dir_addr = 7'h00; rd_en = 1'b0; wr_en = 1'b1; wr_data = 8'hA5; irp = 1'b1;
    #2;
    check("R7", "addr in write cycle", 16'(ram_addr), 16'h004);
    check("R6", "indirect ptr write no we", 16'(ram_we), 16'h0);
    @(negedge clk);
    wr_en = 1'b0; rd_en = 1'b1;
    #2;
    check("R7", "addr after write", 16'(ram_addr), 16'h0A5);
    ptr_m = 8'hA5;
    // R3/R4 with pointer bit 7 set and low bits zero
    step(7'h04, 2'd0, 1'b0, 1'b0, 1'b1, 8'h80);
    step(7'h00, 2'd3, 1'b1, 1'b1, 1'b1, 8'h5A);
    step(7'h04, 2'd0, 1'b0, 1'b1, 1'b0, 8'h00);
    check("R4", "pointer kept after void write", 16'(ptr_m), 16'h80);
    // R8: writes during reset ignored, pointer survives reset
    @(negedge clk); rst_n = 1'b0;
    step(7'h04, 2'd0, 1'b0, 1'b0, 1'b1, 8'h55);
    step(7'h12, 2'd1, 1'b0, 1'b0, 1'b1, 8'h55);
    @(negedge clk); rst_n = 1'b1;
    step(7'h04, 2'd0, 1'b0, 1'b1, 1'b0, 8'h00);
    check("R8", "pointer after reset", 16'(rd_ovr_data), 16'h80);
    // random mix
    for (int i = 0; i < 3000; i++) begin
      logic [6:0] d;
      logic [7:0] wd;
      int r;
      r = int'($urandom % 8);
      d = (r < 2) ? 7'h00 : (r == 2 ? 7'h04 : 7'($urandom));
      r = int'($urandom % 8);
      wd = (r < 2) ? {1'($urandom), 7'h00} : (r == 2 ? {1'($urandom), 7'h04} : 8'($urandom));
      step(d, 2'($urandom), 1'($urandom), 1'($urandom), ($urandom % 5) < 2, wd);
    end
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule